// File: doc/BRIEF.md
# Maskable Interrupt Request Line Arbiter

This block gathers a set of device interrupt request lines (16 by default) and offers the core at most one request at a time. Each request is given as an interrupt vector, and line n maps to vector 32 + n. A rising edge on a line is latched as pending. When the core acknowledges the request on offer, that line moves from pending to in service. The line stays blocked until software reports end of service for it, and other lines can still interrupt the handler, so handlers nest.

Delivery also depends on two inputs. A global enable input follows the core's interrupt-enable flag. A per-line mask lets software hold a single source back. Pending requests are kept while they are held back and are offered again once the hold is lifted. When several lines are eligible, the lowest-numbered one is offered first.

Top module: `irq_arbiter`

## Requirements
- R1: While `req_valid` is high, `req_vector` equals 32 plus the index of the offered line, so line 0 gives 32 and line 15 gives 47.
- R2: A rising edge on `irq_in[n]` sets that line's pending bit, and the request can appear on the outputs two clock edges after the rising input is sampled. A line held high does not raise a new request, and a one-cycle pulse is latched.
- R3: `ack` high while `req_valid` is high clears the offered line's pending bit and marks the line in service. `ack` while `req_valid` is low has no effect.
- R4: A line that is in service is never offered. A new edge on that line sets its pending bit, and the request is held until the line's end of service.
- R5: While one line is in service, a different pending and unmasked line is still offered.
- R6: While `glob_en` is low, `req_valid` is low. Pending requests are kept and are offered once `glob_en` returns high.
- R7: A line whose `line_mask` bit is 1 still latches edges into its pending bit but is never offered. Clearing the mask bit makes the held request eligible.
- R8: Among the lines that are pending, unmasked and not in service, the lowest-numbered line is offered.
- R9: `eos_valid` with an `eos_line` that is not in service has no effect.
- R10: `eos_valid` with `eos_line` = n clears line n's in-service bit, and a request already pending on n becomes eligible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Device request lines, edge sensitive |
| line_mask | input | 16 | Per-line mask, 1 blocks delivery |
| glob_en | input | 1 | Global interrupt enable from the core |
| ack | input | 1 | Core accepts the offered vector |
| eos_valid | input | 1 | End-of-service strobe |
| eos_line | input | 4 | Line number that finishes service |
| req_valid | output | 1 | A request is on offer |
| req_vector | output | 8 | Vector of the offered line |

## Verification
The hardest case to reach is nesting combined with blocking. It needs one line in service, a second edge latched on that same line, a different line offered and acknowledged over it, and then end-of-service strobes for a line that is not busy and for the blocked line, in that order. Directed sequences build this situation with one-cycle pulses at exact cycles. A long seeded random phase then mixes sparse edges, mask and enable changes, and acknowledge and end-of-service strobes, and it compares the outputs in every cycle against a bench model of the pending and in-service sets.

// File: rtl/irq_arb_pkg.sv
// Shared defaults for the interrupt line arbiter.
// Assumes: vector numbering is contiguous from a base value.
package irq_arb_pkg;
    localparam int DEF_LINES    = 16;
    localparam int DEF_VEC_BASE = 32;
    localparam int DEF_VEC_W    = 8;
endpackage

// File: rtl/irq_edge_capture.sv
// Registers each request line and reports a one-cycle rising-edge strobe.
// Assumes: request lines are synchronous to clk.
module irq_edge_capture #(
    parameter int NUM_LINES = irq_arb_pkg::DEF_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] rise_out
);
    logic [NUM_LINES-1:0] stage1_q;
    logic [NUM_LINES-1:0] stage2_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Two sample stages per line; the rise is seen between them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[g] <= 1'b0;
                stage2_q[g] <= 1'b0;
            end else begin
                stage1_q[g] <= lines_in[g];
                stage2_q[g] <= stage1_q[g];
            end
        end
        // Strobe for a low-to-high transition.
        assign rise_out[g] = stage1_q[g] & ~stage2_q[g];
    end
endmodule

// File: rtl/irq_status_regs.sv
// Holds the pending and in-service sets for all lines.
// Assumes: ack_set is one-hot or zero; a new edge wins over an ack clear.
module irq_status_regs #(
    parameter int NUM_LINES = irq_arb_pkg::DEF_LINES,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rise_in,
    input  logic [NUM_LINES-1:0] ack_set,
    input  logic                 eos_valid,
    input  logic [ID_W-1:0]      eos_line,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] busy_q
);
    logic [NUM_LINES-1:0] eos_clr;

    // Decode the end-of-service line number into a clear mask.
    always_comb begin
        eos_clr = '0;
        if (eos_valid) eos_clr[eos_line] = 1'b1;
    end

    // Update pending (edges set, ack clears) and in-service (ack sets, end-of-service clears).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            busy_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_set) | rise_in;
            busy_q <= (busy_q & ~eos_clr) | ack_set;
        end
    end
endmodule

// File: rtl/irq_priority_pick.sv
// Finds the lowest-numbered asserted bit of the eligible vector.
// Assumes: nothing about the number of asserted bits.
module irq_priority_pick #(
    parameter int NUM_LINES = irq_arb_pkg::DEF_LINES,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] elig,
    output logic                 any,
    output logic [ID_W-1:0]      win_idx
);
    // Scan from the top down so that the lowest index is the last written.
    always_comb begin
        win_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (elig[i]) win_idx = ID_W'(i);
        end
        any = |elig;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Top of the arbiter: edge capture, status sets, mask and enable gating,
// lowest-first selection and conversion to a vector number.
// Assumes: ack is taken only in a cycle where req_valid is high.
module irq_arbiter #(
    parameter int NUM_LINES  = irq_arb_pkg::DEF_LINES,
    parameter int VEC_BASE   = irq_arb_pkg::DEF_VEC_BASE,
    parameter int VEC_W      = irq_arb_pkg::DEF_VEC_W,
    localparam int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] line_mask,
    input  logic                 glob_en,
    input  logic                 ack,
    input  logic                 eos_valid,
    input  logic [ID_W-1:0]      eos_line,
    output logic                 req_valid,
    output logic [VEC_W-1:0]     req_vector
);
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] busy;
    logic [NUM_LINES-1:0] elig;
    logic [NUM_LINES-1:0] ack_set;
    logic                 any;
    logic [ID_W-1:0]      win_idx;

    irq_edge_capture #(.NUM_LINES(NUM_LINES)) edge_i (
        .clk(clk), .rst_n(rst_n), .lines_in(irq_in), .rise_out(rise)
    );

    irq_status_regs #(.NUM_LINES(NUM_LINES)) stat_i (
        .clk(clk), .rst_n(rst_n), .rise_in(rise), .ack_set(ack_set),
        .eos_valid(eos_valid), .eos_line(eos_line),
        .pend_q(pend), .busy_q(busy)
    );

    // A line competes only if pending, unmasked and not in service.
    assign elig = pend & ~line_mask & ~busy;

    irq_priority_pick #(.NUM_LINES(NUM_LINES)) pick_i (
        .elig(elig), .any(any), .win_idx(win_idx)
    );

    // The offer is gated by the global enable.
    assign req_valid  = any & glob_en;
    assign req_vector = VEC_W'(VEC_BASE) + VEC_W'(win_idx);

    // A handshake on the offered line turns it from pending to in service.
    always_comb begin
        ack_set = '0;
        if (ack && req_valid) ack_set[win_idx] = 1'b1;
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
// Port-level checker for irq_arbiter, attached by bind.
// Keeps its own record of acknowledged lines from the handshake ports.
module irq_arbiter_chk #(
    parameter int NUM_LINES = 16,
    parameter int VEC_BASE  = 32,
    parameter int VEC_W     = 8,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_mask,
    input logic                 glob_en,
    input logic                 ack,
    input logic                 eos_valid,
    input logic [ID_W-1:0]      eos_line,
    input logic                 req_valid,
    input logic [VEC_W-1:0]     req_vector
);
    logic [NUM_LINES-1:0] seen_busy;
    logic [ID_W-1:0]      off_idx;

    assign off_idx = ID_W'(req_vector - VEC_W'(VEC_BASE));

    // Record lines accepted by the core until their end of service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_busy <= '0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (ack && req_valid && off_idx == ID_W'(i)) seen_busy[i] <= 1'b1;
                else if (eos_valid && eos_line == ID_W'(i)) seen_busy[i] <= 1'b0;
            end
        end
    end

    a_r1_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_vector >= VEC_W'(VEC_BASE) &&
                       req_vector <  VEC_W'(VEC_BASE + NUM_LINES)));

    a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !req_valid);

    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !line_mask[off_idx]);

    a_r4_no_reraise: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !seen_busy[off_idx]);

    a_r3_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_valid) |=> !(req_valid && req_vector == $past(req_vector)));
endmodule

bind irq_arbiter irq_arbiter_chk #(
    .NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .line_mask(line_mask), .glob_en(glob_en),
    .ack(ack), .eos_valid(eos_valid), .eos_line(eos_line),
    .req_valid(req_valid), .req_vector(req_vector)
);

// File: tb/irq_arbiter_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners then seeded random traffic,
// compared each cycle against a model of the pending and in-service sets.
module irq_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [15:0] line_mask = '0;
    logic        glob_en = 1'b1;
    logic        ack = 1'b0;
    logic        eos_valid = 1'b0;
    logic [3:0]  eos_line = '0;
    logic        req_valid;
    logic [7:0]  req_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_s1 = '0, m_s2 = '0, m_pend = '0, m_busy = '0;

    always #2.5 clk = ~clk;

    irq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_mask(line_mask),
        .glob_en(glob_en), .ack(ack), .eos_valid(eos_valid), .eos_line(eos_line),
        .req_valid(req_valid), .req_vector(req_vector)
    );

    // Expected offered line from the requirements, or -1 for none.
    function automatic int ref_pick(logic [15:0] p, logic [15:0] b, logic [15:0] m, logic en);
        if (!en) return -1;
        for (int i = 0; i < 16; i++) if (p[i] && !b[i] && !m[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: apply driven inputs, advance the model, compare at the negedge.
    task automatic tick();
        int sel;
        logic [15:0] rise, aset, eclr;
        sel = ref_pick(m_pend, m_busy, line_mask, glob_en);
        @(posedge clk);
        rise = m_s1 & ~m_s2;
        m_s2 = m_s1;
        m_s1 = irq_in;
        aset = (ack && sel >= 0) ? (16'd1 << sel) : 16'd0;
        eclr = eos_valid ? (16'd1 << eos_line) : 16'd0;
        m_pend = (m_pend & ~aset) | rise;
        m_busy = (m_busy & ~eclr) | aset;
        @(negedge clk);
        ack = 1'b0;
        eos_valid = 1'b0;
        sel = ref_pick(m_pend, m_busy, line_mask, glob_en);
        chk(req_valid == (sel >= 0), "R6 R7 R4 valid", int'(req_valid), int'(sel >= 0));
        if (sel >= 0) chk(req_vector == 8'(32 + sel), "R1 R8 vector", int'(req_vector), 32 + sel);
    endtask

    task automatic pulse(input logic [15:0] bits);
        irq_in = bits; tick(); irq_in = '0; tick();
    endtask

    task automatic do_ack(); ack = 1'b1; tick(); endtask
    task automatic do_eos(input int n); eos_valid = 1'b1; eos_line = 4'(n); tick(); endtask

    initial begin
        #500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R2 reset idle", int'(req_valid), 0);

        // R1 R2: held level on line 5 gives vector 37 once.
        irq_in = 16'h0020; tick(); tick();
        chk(req_valid && req_vector == 8'd37, "R1 R2 line5", int'(req_vector), 37);
        do_ack();
        chk(!req_valid, "R3 ack retires", int'(req_valid), 0);
        do_eos(5); tick();
        chk(!req_valid, "R2 level no retrigger", int'(req_valid), 0);
        irq_in = '0; tick(); tick();
        ack = 1'b1; tick();
        chk(!req_valid && m_busy == 16'h0, "R3 stray ack ignored", int'(req_valid), 0);

        // R4 R5 R9 R10: nesting and blocking.
        pulse(16'h0200);
        chk(req_valid && req_vector == 8'd41, "R2 pulse latched", int'(req_vector), 41);
        do_ack();
        pulse(16'h0200);
        chk(!req_valid, "R4 busy line held", int'(req_valid), 0);
        pulse(16'h1000);
        chk(req_valid && req_vector == 8'd44, "R5 nesting", int'(req_vector), 44);
        do_ack();
        do_eos(3);
        chk(!req_valid, "R9 stray eos", int'(req_valid), 0);
        do_eos(9);
        chk(req_valid && req_vector == 8'd41, "R10 eos releases", int'(req_vector), 41);
        do_ack(); do_eos(12); do_eos(9);

        // R8 R7 R6: priority, mask, enable.
        pulse(16'h8084);
        chk(req_valid && req_vector == 8'd34, "R8 lowest wins", int'(req_vector), 34);
        line_mask = 16'h0004; tick();
        chk(req_valid && req_vector == 8'd39, "R7 masked skipped", int'(req_vector), 39);
        glob_en = 1'b0; tick(); tick();
        chk(!req_valid, "R6 disabled", int'(req_valid), 0);
        glob_en = 1'b1; tick();
        chk(req_valid && req_vector == 8'd39, "R6 pending kept", int'(req_vector), 39);
        line_mask = '0; tick();
        chk(req_valid && req_vector == 8'd34, "R7 unmask", int'(req_vector), 34);
        for (int k = 0; k < 3; k++) do_ack();
        do_eos(2); do_eos(7); do_eos(15);
        chk(!req_valid, "R10 drained", int'(req_valid), 0);

        // Random traffic against the model.
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < 16; i++) if ($urandom % 12 == 0) irq_in[i] = ~irq_in[i];
            if ($urandom % 40 == 0) line_mask = 16'($urandom) & 16'($urandom);
            if ($urandom % 30 == 0) glob_en = ~glob_en;
            ack = ($urandom % 3 == 0);
            if ($urandom % 4 == 0) begin eos_valid = 1'b1; eos_line = 4'($urandom); end
            tick();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule